// File: doc/BRIEF.md
# Maskable-Write GPIO Bank

This block is one 32-pin general-purpose I/O bank with a 32-bit register port. It keeps an output value latch, a per-pin direction register and a per-pin drive-enable register. It also gives a read-only view of the pad levels after a two-stage synchroniser. Each pad drives its output value only when both its direction bit and its drive-enable bit are set. Otherwise the pad is left tristated.

Software changes output bits through two write-only half-word ports. One port covers pins 0 to 15 and the other covers pins 16 to 31. Each write carries a 16-bit mask in its upper half and 16 data bits in its lower half. A data bit reaches the latch only where its mask bit is zero. Any subset of pins can therefore be set or cleared in one bus write, with no read-modify-write and no race against another agent that owns other pins of the same bank.

The bus side is a plain single-cycle request. A valid strobe, a write flag, an address and write data arrive together. Read data is combinational in the same cycle and is zero when no read is requested. The bank index is a parameter, and it places the five decoded addresses inside a shared multi-bank map.

Top module: `gpio_mask_bank`

## Requirements
- R1: After a cycle with `rst_n` low, the direction register, the drive-enable register and the output latch are all zero. `pad_oe` and `pad_out` are therefore both zero.
- R2: A write to the low half port (byte address 8·BANK_IDX) copies `bus_wdata[i]` into the output latch for pin i (0 ≤ i ≤ 15) wherever mask bit `bus_wdata[16+i]` is 0.
- R3: Latch bits whose mask bit is 1 keep their previous value. An all-ones mask leaves the whole latch unchanged.
- R4: A write to the high half port (byte address 8·BANK_IDX + 4) treats `bus_wdata[i]` as the data for pin 16+i, with mask bit `bus_wdata[16+i]` active low. Pins 0 to 15 are not affected.
- R5: The direction register (address 0x204 + 0x40·BANK_IDX) is read/write. Bit i = 1 selects output for pin i, and a read returns the last value written.
- R6: The drive-enable register (address 0x208 + 0x40·BANK_IDX) is read/write. A read returns the last value written.
- R7: `pad_oe[i]` is 1 exactly when direction bit i and drive-enable bit i are both 1. `pad_out` always presents the output latch.
- R8: A read of the level register (address 0x060 + 4·BANK_IDX) returns the value `pad_in` held two rising edges earlier. Writes to this address change nothing.
- R9: A read of either half port, or of any address that is not decoded, returns 0. A write to an address that is not decoded changes no register.
- R10: A register write takes effect at the rising edge on which it is presented. The outputs do not change in any cycle without a write to the matching address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Request strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the GPIO map |
| bus_wdata | input | WORD_W | Write data, or mask and data for the half ports |
| bus_rdata | output | WORD_W | Read data, valid in the cycle of the read |
| pad_in | input | WORD_W | Raw pad levels, asynchronous to `clk` |
| pad_out | output | WORD_W | Output latch value toward the pads |
| pad_oe | output | WORD_W | Per-pin drive enable toward the pads |

## Verification
The assertions assume that the request signals are stable around each rising edge. They also assume that `pad_in` changes only between edges, so that a two-edge-old sample of `pad_in` is a meaningful reference for the synchroniser. The stimulus drives every bus field and `pad_in` on the falling edge only. It holds `pad_in` constant for several cycles around each level read, so the latency check sees defined history. Addresses come from the same bank parameters that the design uses, plus one deliberately undecoded offset.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the maskable GPIO bank: register selector type and
// address arithmetic of the multi-bank map. Assumes byte addressing.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_LO   = 3'd1,
        SEL_HI   = 3'd2,
        SEL_LVL  = 3'd3,
        SEL_DIR  = 3'd4,
        SEL_OE   = 3'd5
    } reg_sel_e;

    // Low half maskable port of a bank.
    function automatic int unsigned lo_port_addr(input int unsigned bank);
        return 32'h000 + 8 * bank;
    endfunction

    // High half maskable port of a bank.
    function automatic int unsigned hi_port_addr(input int unsigned bank);
        return 32'h004 + 8 * bank;
    endfunction

    // Synchronised pin level view of a bank.
    function automatic int unsigned lvl_addr(input int unsigned bank);
        return 32'h060 + 4 * bank;
    endfunction

    // Direction register of a bank.
    function automatic int unsigned dir_addr(input int unsigned bank);
        return 32'h204 + 32'h40 * bank;
    endfunction

    // Drive-enable register of a bank.
    function automatic int unsigned oe_addr(input int unsigned bank);
        return 32'h208 + 32'h40 * bank;
    endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
// Address decoder: maps a byte address to one of the bank's five registers.
// Assumes the map addresses of the chosen bank fit in ADDR_W bits.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int BANK_IDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(lo_port_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(hi_port_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(lvl_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(dir_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] OE_A  = ADDR_W'(oe_addr(BANK_IDX));

    // Pick the register selected by the address; anything else is none.
    always_comb begin
        sel = SEL_NONE;
        if (addr == LO_A)       sel = SEL_LO;
        else if (addr == HI_A)  sel = SEL_HI;
        else if (addr == LVL_A) sel = SEL_LVL;
        else if (addr == DIR_A) sel = SEL_DIR;
        else if (addr == OE_A)  sel = SEL_OE;
    end

endmodule

// File: rtl/gpio_half_latch.sv
// One half of the output latch. The upper HALF_W bits of the write word are an
// active-low per-bit mask; the lower HALF_W bits are the data.
// Assumes wr_en is a single-cycle qualified write strobe.
module gpio_half_latch #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2*HALF_W-1:0] word,
    output logic [HALF_W-1:0]   q
);

    logic [HALF_W-1:0] mask_n;
    logic [HALF_W-1:0] data;

    assign mask_n = word[2*HALF_W-1:HALF_W];
    assign data   = word[HALF_W-1:0];

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        // Update one latch bit when written with its mask bit clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (wr_en && !mask_n[i])
                q[i] <= data[i];
        end
    end

endmodule

// File: rtl/gpio_cfg_reg.sv
// Plain read/write configuration register, cleared by reset.
module gpio_cfg_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    // Load the full word on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchroniser for asynchronous pad levels. Assumes each bit is
// sampled independently (no multi-bit coherence is promised).
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the sampled level one stage further, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= din;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_mask_bank.sv
// GPIO bank top: decoder, two maskable half latches, direction and drive-enable
// registers, input synchroniser and read mux. Assumes a single-cycle request
// port with combinational read data and WORD_W even.
module gpio_mask_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int BANK_IDX = 0,
    parameter int WORD_W   = 32,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] pad_in,
    output logic [WORD_W-1:0] pad_out,
    output logic [WORD_W-1:0] pad_oe
);

    localparam int HALF_W = WORD_W / 2;
    localparam int HALVES = 2;

    reg_sel_e          sel;
    logic              wr_fire;
    logic              rd_fire;
    logic [WORD_W-1:0] dir_q;
    logic [WORD_W-1:0] oe_q;
    logic [WORD_W-1:0] lvl_q;
    logic [WORD_W-1:0] out_q;

    assign wr_fire = bus_valid && bus_write;
    assign rd_fire = bus_valid && !bus_write;

    gpio_bank_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_IDX (BANK_IDX)
    ) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam reg_sel_e HSEL = (h == 0) ? SEL_LO : SEL_HI;
        gpio_half_latch #(
            .HALF_W (HALF_W)
        ) latch_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_fire && (sel == HSEL)),
            .word  (bus_wdata),
            .q     (out_q[h*HALF_W +: HALF_W])
        );
    end

    gpio_cfg_reg #(
        .WIDTH (WORD_W)
    ) dir_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_fire && (sel == SEL_DIR)),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    gpio_cfg_reg #(
        .WIDTH (WORD_W)
    ) oe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_fire && (sel == SEL_OE)),
        .wdata (bus_wdata),
        .q     (oe_q)
    );

    gpio_in_sync #(
        .WIDTH  (WORD_W),
        .STAGES (SYNC_N)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (lvl_q)
    );

    // Return the selected readable register; write-only and unmapped read 0.
    always_comb begin
        bus_rdata = '0;
        if (rd_fire) begin
            case (sel)
                SEL_LVL: bus_rdata = lvl_q;
                SEL_DIR: bus_rdata = dir_q;
                SEL_OE:  bus_rdata = oe_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q & oe_q;

endmodule

// File: rtl/gpio_bank_chk.sv
// Property checker for gpio_mask_bank, attached by bind. Observes ports only.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int BANK_IDX = 0,
    parameter int WORD_W   = 32,
    parameter int SYNC_N   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] pad_in,
    input logic [WORD_W-1:0] pad_out,
    input logic [WORD_W-1:0] pad_oe
);

    localparam int HW = WORD_W / 2;
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(lo_port_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(hi_port_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(lvl_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(dir_addr(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(oe_addr(BANK_IDX));

    logic       wr, rd;
    logic [1:0] run_cyc;

    assign wr = bus_valid && bus_write;
    assign rd = bus_valid && !bus_write;

    // Count edges since reset release, saturating, to gate history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cyc <= 2'd0;
        else if (run_cyc != 2'd3)
            run_cyc <= run_cyc + 2'd1;
    end

    // R1: first cycle after reset shows every pad tristated with latch clear.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // R2, R3: low port merges data under the active-low mask.
    p_lo_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_LO) |=>
        (pad_out[HW-1:0] == (($past(pad_out[HW-1:0]) & $past(bus_wdata[WORD_W-1:HW]))
                           | ($past(bus_wdata[HW-1:0]) & ~$past(bus_wdata[WORD_W-1:HW]))))
        && $stable(pad_out[WORD_W-1:HW]));

    // R4: high port merges into the upper pins only.
    p_hi_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_HI) |=>
        (pad_out[WORD_W-1:HW] == (($past(pad_out[WORD_W-1:HW]) & $past(bus_wdata[WORD_W-1:HW]))
                                | ($past(bus_wdata[HW-1:0]) & ~$past(bus_wdata[WORD_W-1:HW]))))
        && $stable(pad_out[HW-1:0]));

    // R10: output latch holds without a half-port write.
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == A_LO || bus_addr == A_HI)) |=> $stable(pad_out));

    // R7: drive enables hold without a direction or drive-enable write.
    p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == A_DIR || bus_addr == A_OE)) |=> $stable(pad_oe));

    // R8: level read returns pad_in from two edges earlier.
    p_lvl_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == A_LVL && run_cyc == 2'd3) |-> bus_rdata == $past(pad_in, 2));

    // R9: write-only half ports read as zero.
    p_wo_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (bus_addr == A_LO || bus_addr == A_HI)) |-> bus_rdata == '0);

    // R9: no read, no data.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> bus_rdata == '0);

endmodule

bind gpio_mask_bank gpio_bank_chk #(
    .ADDR_W   (ADDR_W),
    .BANK_IDX (BANK_IDX),
    .WORD_W   (WORD_W),
    .SYNC_N   (SYNC_N)
) chk_i (.*);

// File: tb/gpio_mask_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_bank_tb_top;

    localparam int AW   = 10;
    localparam int BANK = 0;
    localparam int W    = 32;

    localparam logic [AW-1:0] A_LO  = AW'(32'h000 + 8 * BANK);
    localparam logic [AW-1:0] A_HI  = AW'(32'h004 + 8 * BANK);
    localparam logic [AW-1:0] A_LVL = AW'(32'h060 + 4 * BANK);
    localparam logic [AW-1:0] A_DIR = AW'(32'h204 + 32'h40 * BANK);
    localparam logic [AW-1:0] A_OE  = AW'(32'h208 + 32'h40 * BANK);
    localparam logic [AW-1:0] A_BAD = AW'(32'h100);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state.
    logic [W-1:0] m_out = '0;
    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_oe  = '0;
    logic [W-1:0] m_hist[$];

    always #2 clk = ~clk;

    gpio_mask_bank #(.ADDR_W(AW), .BANK_IDX(BANK), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural model, advanced on each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_oe = '0;
            m_hist.push_front('0);
        end else begin
            if (bus_valid && bus_write) begin
                if (bus_addr == A_LO || bus_addr == A_HI) begin
                    for (int i = 0; i < W/2; i++)
                        if (!bus_wdata[W/2 + i])
                            m_out[(bus_addr == A_HI ? W/2 : 0) + i] = bus_wdata[i];
                end
                if (bus_addr == A_DIR) m_dir = bus_wdata;
                if (bus_addr == A_OE)  m_oe  = bus_wdata;
            end
            m_hist.push_front(pad_in);
        end
        while (m_hist.size() > 2) void'(m_hist.pop_back());
    end

    // Per-cycle comparison of the pad outputs, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 pad_out", pad_out, m_out);
            check("R7 pad_oe", pad_oe, m_dir & m_oe);
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    function automatic logic [W-1:0] lvl_exp();
        return (m_hist.size() > 1) ? m_hist[1] : '0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pad_out reset", pad_out, '0);
        check("R1 pad_oe reset", pad_oe, '0);
        bus_rd(A_DIR, '0, "R1 dir reset");
        bus_rd(A_OE, '0, "R1 oe reset");

        bus_wr(A_DIR, 32'hFFFF_00FF);
        bus_rd(A_DIR, 32'hFFFF_00FF, "R5 dir readback");
        bus_wr(A_OE, 32'h0F0F_0F0F);
        bus_rd(A_OE, 32'h0F0F_0F0F, "R6 oe readback");
        check("R7 pad_oe gate", pad_oe, 32'h0F0F_000F);

        bus_wr(A_LO, 32'h0000_A5A5);
        check("R2 low full write", pad_out, 32'h0000_A5A5);
        bus_wr(A_LO, 32'hFFFE_0000);
        check("R3 clear bit0 only", pad_out, 32'h0000_A5A4);
        bus_wr(A_LO, 32'h7FFF_8000);
        check("R2 set bit15 only", pad_out, 32'h0000_A5A4);
        bus_wr(A_LO, 32'hFFFF_1234);
        check("R3 all-mask no change", pad_out, 32'h0000_A5A4);

        bus_wr(A_HI, 32'h0000_C3C3);
        check("R4 high full write", pad_out, 32'hC3C3_A5A4);
        bus_wr(A_HI, 32'hFFEF_0010);
        check("R4 pin20 set", pad_out, 32'hC3D3_A5A4);

        bus_rd(A_LO, '0, "R9 low port reads 0");
        bus_rd(A_HI, '0, "R9 high port reads 0");
        bus_rd(A_BAD, '0, "R9 undecoded reads 0");
        bus_wr(A_BAD, 32'hDEAD_BEEF);
        check("R9 undecoded write out", pad_out, 32'hC3D3_A5A4);
        bus_rd(A_DIR, 32'hFFFF_00FF, "R9 undecoded write dir");
        bus_rd(A_OE, 32'h0F0F_0F0F, "R9 undecoded write oe");
        bus_wr(A_LVL, 32'hFFFF_FFFF);
        check("R8 level write ignored", pad_out, 32'hC3D3_A5A4);

        @(negedge clk);
        pad_in = 32'h1234_5678;
        bus_rd(A_LVL, lvl_exp(), "R8 level one edge");
        bus_rd(A_LVL, 32'h1234_5678, "R8 level settled");
        @(negedge clk);
        pad_in = 32'h8765_4321;
        bus_rd(A_LVL, 32'h1234_5678, "R8 old level after one edge");
        bus_rd(A_LVL, 32'h8765_4321, "R8 new level after two edges");

        bus_wr(A_DIR, 32'h0000_0000);
        check("R7 dir clear tristates", pad_oe, '0);
        check("R7 pad_out still latched", pad_out, 32'hC3D3_A5A4);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 re-reset pad_out", pad_out, '0);
        check("R1 re-reset pad_oe", pad_oe, '0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule